// File: doc/BRIEF.md
# Register Block with Undefined-Address Error Detection

This block is a small memory-mapped register file behind a plain strobe bus. A host presents an address with a read strobe or a write strobe. Writes land in one of a few 32-bit registers, each made of an upper and a lower 16-bit field. Reads return the selected register's contents in the same cycle, together with a valid flag.

Some addresses inside the block's window have no register behind them, and so does everything past the end of the window. The block finds these addresses with one inclusive range comparator per gap and one overflow comparator. A policy parameter, fixed when the block is instantiated, decides which transaction directions drive the error output high when they hit such an address. The choices are reads only, writes only, neither (reads return zero and writes are dropped), or both.

The register window starts at `BASE`. The block is meant to sit under a bus adapter that decodes a larger map and fans out strobes.

Top module: `regblk_guard`

## Requirements
- R1: While `rst` is high on a rising clock edge, every register is cleared to zero. After reset, each register reads back as 0x00000000.
- R2: A write strobe to a mapped address stores `wdata` into that register on the same rising edge, with bits 31:16 as the upper field and bits 15:0 as the lower field. A later read returns the stored value. A read in the same cycle as the write returns the old value.
- R3: `rd_valid` equals `rd_stb` in the same cycle. `rdata` is zero when `rd_stb` is low, and zero when the read address is not mapped.
- R4: Register 0 occupies BASE+0x00..0x03. Register i (i ≥ 1) occupies BASE+0x20+4·(i−1) through the next three bytes. The two low address bits select nothing inside a register.
- R5: The undefined addresses are BASE+0x04..0x1F, the span from just past the last register through BASE+BLK_SIZE−1, and any address above BASE+BLK_SIZE−1. Addresses below BASE are not decoded: they never raise the error and they read as zero.
- R6: With the write-only policy, the error is high only when `wr_stb` is high on an undefined address.
- R7: With the read-only policy, the error is high only when `rd_stb` is high on an undefined address.
- R8: With the silent policy, the error never rises. Undefined reads return zero.
- R9: With the both-directions policy, the error is high when either strobe is high on an undefined address.
- R10: Under every policy, a write to an undefined address or to an address below BASE leaves every register unchanged.
- R11: The error output is combinational. It is high only in the cycle in which the qualifying strobe is present, and low in any cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Byte address of the access |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when not reading a mapped register |
| rd_valid | output | 1 | Read data valid, same cycle as `rd_stb` |
| err | output | 1 | Undefined-address error, gated by policy |

## Verification
The bench runs four copies of the block, one per policy, on the same stimulus. A policy that flags the wrong direction therefore shows up as an error on the wrong strobe in one of the copies.

Several boundary addresses are targeted directly. The first and last bytes of each gap are probed, and an off-by-one comparator would either flag a live register byte or miss a gap byte. The first address past the window is probed, and a missing overflow term would let it through silently. An address just below BASE is probed, and an unanchored decoder would flag or alias it.

Writes are aimed at holes and followed by reads of every register, so a write that leaks into a neighbour becomes visible. Reads in the same cycle as a write are checked as well: a design that forwards write data would return the new value a cycle early.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

    localparam int FIELD_W = 16;
    localparam int WORD_W  = 2 * FIELD_W;
    localparam int LO_GAP_START = 32'h04;
    localparam int LO_GAP_END   = 32'h1F;
    localparam int UPPER_BANK   = 32'h20;
    localparam int GAP_COUNT    = 2;

    typedef enum logic [1:0] {
        ERR_ON_READ  = 2'd0,
        ERR_ON_WRITE = 2'd1,
        ERR_NONE     = 2'd2,
        ERR_ON_BOTH  = 2'd3
    } err_policy_e;

    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } word_t;

    // relative byte offset of register slot i
    function automatic int slot_offset(input int i);
        return (i == 0) ? 0 : UPPER_BANK + 4 * (i - 1);
    endfunction

    // inclusive relative bounds of gap k
    function automatic int gap_low(input int k, input int nregs);
        return (k == 0) ? LO_GAP_START : slot_offset(nregs - 1) + 4;
    endfunction

    function automatic int gap_high(input int k, input int blk_size);
        return (k == 0) ? LO_GAP_END : blk_size - 1;
    endfunction

    function automatic logic policy_flags_read(input err_policy_e p);
        return (p == ERR_ON_READ) || (p == ERR_ON_BOTH);
    endfunction

    function automatic logic policy_flags_write(input err_policy_e p);
        return (p == ERR_ON_WRITE) || (p == ERR_ON_BOTH);
    endfunction

endpackage

// File: rtl/regblk_decode.sv
module regblk_decode
    import regblk_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BASE     = 32'h40,
    parameter int NUM_REGS = 4,
    parameter int BLK_SIZE = 32'h40
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] slot_sel,
    output logic                undef
);
    localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(BASE + BLK_SIZE - 1);

    logic [GAP_COUNT-1:0] gap_hit;
    logic                 past_end;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE + slot_offset(i));
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + slot_offset(i) + 3);
        assign slot_sel[i] = (addr >= LO) && (addr <= HI);
    end

    for (genvar k = 0; k < GAP_COUNT; k++) begin : g_gap
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE + gap_low(k, NUM_REGS));
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + gap_high(k, BLK_SIZE));
        if (gap_low(k, NUM_REGS) <= gap_high(k, BLK_SIZE)) begin : g_live
            assign gap_hit[k] = (addr >= LO) && (addr <= HI);
        end else begin : g_empty
            assign gap_hit[k] = 1'b0;
        end
    end

    assign past_end = addr > END_ADDR;
    assign undef    = (|gap_hit) | past_end;

endmodule

// File: rtl/regblk_slot.sv
module regblk_slot
    import regblk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  rd_en,
    input  word_t wdata,
    output word_t rd_term
);
    word_t store;

    always_ff @(posedge clk) begin
        if (rst)        store <= '0;
        else if (wr_en) store <= wdata;
    end

    assign rd_term = rd_en ? store : '0;

    // R2
    slot_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (store == $past(wdata)));

    // R10
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(store));

endmodule

// File: rtl/regblk_errgen.sv
module regblk_errgen
    import regblk_pkg::*;
#(
    parameter err_policy_e POLICY = ERR_ON_BOTH
) (
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic undef,
    output logic err
);
    localparam logic FLAG_RD = policy_flags_read(POLICY);
    localparam logic FLAG_WR = policy_flags_write(POLICY);

    always_comb begin
        err = 1'b0;
        if (undef) err = (FLAG_RD & rd_stb) | (FLAG_WR & wr_stb);
    end

endmodule

// File: rtl/regblk_guard.sv
module regblk_guard
    import regblk_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          BASE     = 32'h40,
    parameter int          NUM_REGS = 4,
    parameter int          BLK_SIZE = 32'h40,
    parameter err_policy_e POLICY   = ERR_ON_BOTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rd_valid,
    output logic              err
);
    logic [NUM_REGS-1:0] slot_sel;
    logic                undef;
    word_t               terms [NUM_REGS];

    regblk_decode #(
        .ADDR_W(ADDR_W), .BASE(BASE), .NUM_REGS(NUM_REGS), .BLK_SIZE(BLK_SIZE)
    ) u_dec (
        .addr(addr), .slot_sel(slot_sel), .undef(undef)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        regblk_slot u_slot (
            .clk(clk), .rst(rst),
            .wr_en(wr_stb & slot_sel[i]),
            .rd_en(rd_stb & slot_sel[i]),
            .wdata(word_t'(wdata)),
            .rd_term(terms[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) rdata = rdata | terms[i];
    end

    assign rd_valid = rd_stb;

    regblk_errgen #(.POLICY(POLICY)) u_err (
        .rd_stb(rd_stb), .wr_stb(wr_stb), .undef(undef), .err(err)
    );

    // R5
    decode_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        !(undef && (|slot_sel)));

    // R4
    single_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_sel));

    // R11
    err_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (undef && (rd_stb || wr_stb)));

    // R3
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rdata != '0) |-> (rd_stb && (|slot_sel)));

    // R6 R7 R8 R9
    err_policy_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ((rd_stb && policy_flags_read(POLICY)) ||
                 (wr_stb && policy_flags_write(POLICY))));

endmodule

// File: tb/sim_regblk_guard.sv
module sim_regblk_guard;
    import regblk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int BASE = 32'h40;
    localparam int NREG = 4;
    localparam int BSZ  = 32'h40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_stb = 1'b0, rd_stb = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata [4];
    logic          rvld  [4];
    logic          err   [4];

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    regblk_guard #(.POLICY(ERR_ON_BOTH)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata[0]), .rd_valid(rvld[0]), .err(err[0]));
    regblk_guard #(.POLICY(ERR_ON_READ)) u_rd (
        .clk(clk), .rst(rst), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata[1]), .rd_valid(rvld[1]), .err(err[1]));
    regblk_guard #(.POLICY(ERR_ON_WRITE)) u_wr (
        .clk(clk), .rst(rst), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata[2]), .rd_valid(rvld[2]), .err(err[2]));
    regblk_guard #(.POLICY(ERR_NONE)) u_rz (
        .clk(clk), .rst(rst), .addr(addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .wdata(wdata), .rdata(rdata[3]), .rd_valid(rvld[3]), .err(err[3]));

    // bench view of the map, written from the requirements
    function automatic int map_index(input int a);
        if (a >= BASE && a < BASE + 4) return 0;
        for (int i = 1; i < NREG; i++)
            if (a >= BASE + 32 + 4*(i-1) && a < BASE + 36 + 4*(i-1)) return i;
        return -1;
    endfunction

    function automatic bit is_undefined(input int a);
        return (a >= BASE) && (map_index(a) < 0);
    endfunction

    function automatic string pol_tag(input int k);
        case (k)
            0: return "R9";
            1: return "R7";
            2: return "R6";
            default: return "R8";
        endcase
    endfunction

    function automatic bit pol_rd(input int k);
        return (k == 0) || (k == 1);
    endfunction

    function automatic bit pol_wr(input int k);
        return (k == 0) || (k == 2);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one bus cycle: drive after negedge, compare, then let model follow the edge
    task automatic step(input bit w, input bit r, input int a,
                        input logic [31:0] d, input string tag);
        int idx;
        logic [31:0] exp_rd;
        bit exp_err;
        @(negedge clk);
        wr_stb = w; rd_stb = r; addr = AW'(a); wdata = d;
        #2;
        idx = map_index(a);
        exp_rd = (r && idx >= 0) ? model[idx] : 32'h0;
        for (int k = 0; k < 4; k++) begin
            exp_err = is_undefined(a) && ((r && pol_rd(k)) || (w && pol_wr(k)));
            check(rdata[k] === exp_rd, tag, "rdata", rdata[k], exp_rd);
            check(rvld[k] === r, {tag, "/R3"}, "rd_valid", 32'(rvld[k]), 32'(r));
            check(err[k] === exp_err, {tag, "/", pol_tag(k), "/R11"}, "err",
                  32'(err[k]), 32'(exp_err));
        end
        if (w && idx >= 0) model[idx] = d;
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NREG; i++)
            step(1'b0, 1'b1, BASE + ((i == 0) ? 0 : 32 + 4*(i-1)), 32'h0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        read_all("R1");
        step(1'b0, 1'b0, 0, 32'h0, "R11");

        // R2 R4: writes to each register, byte offsets inside a word
        step(1'b1, 1'b0, BASE + 0,  32'hA5A5_1234, "R2");
        step(1'b1, 1'b0, BASE + 33, 32'hDEAD_BEEF, "R4");
        step(1'b1, 1'b0, BASE + 38, 32'h0001_FFFF, "R4");
        step(1'b1, 1'b1, BASE + 43, 32'hCAFE_0042, "R2");
        read_all("R2");
        step(1'b0, 1'b1, BASE + 3, 32'h0, "R4");

        // R5 R10: gap edges, past end, below base, reads and writes
        step(1'b1, 1'b0, BASE + 4,    32'h1111_1111, "R10");
        step(1'b1, 1'b0, BASE + 31,   32'h2222_2222, "R10");
        step(1'b0, 1'b1, BASE + 4,    32'h0, "R5");
        step(1'b0, 1'b1, BASE + 31,   32'h0, "R5");
        step(1'b1, 1'b0, BASE + 44,   32'h3333_3333, "R10");
        step(1'b0, 1'b1, BASE + 63,   32'h0, "R5");
        step(1'b1, 1'b1, BASE + 64,   32'h4444_4444, "R5");
        step(1'b0, 1'b1, 255,         32'h0, "R5");
        step(1'b1, 1'b1, BASE - 1,    32'h5555_5555, "R5");
        step(1'b1, 1'b0, 0,           32'h6666_6666, "R10");
        read_all("R10");

        // R8 R11: no strobe on undefined address
        step(1'b0, 1'b0, BASE + 8, 32'h7777_7777, "R8");

        // mixed pattern
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            int a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[0] ? int'(lfsr[15:8]) : BASE + map_index_pick(lfsr[3:1]);
            step(lfsr[4], lfsr[5], a, {lfsr, ~lfsr}, "R3");
        end
        read_all("R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic int map_index_pick(input logic [2:0] s);
        case (s)
            3'd0: return 0;
            3'd1: return 32;
            3'd2: return 36;
            3'd3: return 40;
            3'd4: return 4;
            3'd5: return 31;
            3'd6: return 44;
            default: return 2;
        endcase
    endfunction

endmodule